// File: doc/BRIEF.md
# Control Register Write Gate

This block sits between a serial write engine and a bank of clock and control registers. It decides whether a finished write transaction may be committed to the bank. When the engine finishes a transaction, it raises a one-cycle done strobe and presents three things: the start address, the byte count and a buffer of up to `MAX_BYTES` data bytes. The gate answers one cycle later. It either raises a one-cycle commit strobe, or it stays quiet. The bus acknowledge is the engine's business and is never affected by this block.

Two conditions must both hold for a commit. The first is a two-step unlock held in the status register. An arming key (02h) must be written in one transaction, and an opening key (06h) in a later, separate transaction. The second is a length rule for each register group:

- The timekeeping group (`TIME_SPAN` registers from `TIME_BASE`) changes only through one full page that starts at its first register.
- The alarm group (`ALARM_SPAN` registers from `ALARM_BASE`) needs at least two bytes.
- Every other register accepts writes of one byte or more.

Top module: `ccr_write_gate`

## Requirements
- R1: While reset is asserted, and on leaving it, `we_latch`, `rw_enable` and `commit_stb` are all 0, so every register write is blocked until the unlock is repeated.
- R2: A completed write whose start address equals `STATUS_ADDR` updates the unlock bits and never produces `commit_stb`. With byte count 1..`MAX_BYTES`, the key value is the last byte of the transaction, lane `len-1` of `txn_data`, where lane k is bits [8k+7:8k]. Key 02h sets `we_latch` and clears `rw_enable`.
- R3: Key 06h sets both bits when `we_latch` is already 1 before that transaction. When `we_latch` is 0, key 06h clears both bits, so a single transaction carrying 02h then 06h does not unlock. `rw_enable` is never 1 while `we_latch` is 0.
- R4: A status write with any other key value, or with byte count 0 or above `MAX_BYTES`, clears both bits.
- R5: A write to any non-status register while `we_latch` and `rw_enable` are not both 1 gives no commit and leaves both bits unchanged.
- R6: A timekeeping write commits only when it starts at `TIME_BASE` with byte count exactly `TIME_SPAN`. A shorter write, or a page starting inside the group, does not commit.
- R7: An alarm group write commits only with byte count 2..`MAX_BYTES`. A single-byte write to it does not commit.
- R8: A write to any other register commits with byte count 1..`MAX_BYTES` when unlocked.
- R9: The unlock bits change only on status writes. They stay set across committed and rejected register writes.
- R10: `commit_stb` is high exactly in the cycle after an accepted done strobe, for one cycle per transaction, including back-to-back transactions. It is never high without a done strobe in the previous cycle.
- R11: A non-status write with byte count 0 or above `MAX_BYTES` never commits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| txn_done | input | 1 | One-cycle strobe: a write transaction has completed |
| txn_addr | input | ADDR_W | Start register address of the transaction |
| txn_len | input | LEN_W | Number of data bytes received |
| txn_data | input | MAX_BYTES*8 | Received bytes, byte k in lane k |
| commit_stb | output | 1 | One-cycle strobe: commit the transaction to the bank |
| we_latch | output | 1 | First unlock stage (arming key seen) |
| rw_enable | output | 1 | Second unlock stage (register writes enabled) |

## Verification
The assertions assume that `txn_done` is a clean synchronous strobe and that address, length and data are stable in the cycle in which it is high. The assertions look only at start address and length, never at the register span a transaction covers. The stimulus drives every transaction at the falling edge, holds `txn_done` for exactly one cycle, and keeps the address and length fields inside their port widths. It includes back-to-back transactions and a reset in the middle of the run.

// File: rtl/ccr_gate_pkg.sv
package ccr_gate_pkg;

  typedef enum logic [1:0] {
    GRP_OTHER  = 2'd0,
    GRP_ALARM  = 2'd1,
    GRP_TIME   = 2'd2,
    GRP_STATUS = 2'd3
  } grp_e;

  typedef struct packed {
    logic arm;
    logic open;
  } unlock_t;

  function automatic logic in_window(int unsigned a, int unsigned base, int unsigned span);
    return (a >= base) && (a < base + span);
  endfunction

  // Byte-count rule per register group
  function automatic logic len_legal(grp_e g, logic at_base, int unsigned n,
                                     int unsigned span, int unsigned maxb);
    logic ok;
    case (g)
      GRP_TIME:  ok = at_base && (n == span);
      GRP_ALARM: ok = (n >= 2) && (n <= maxb);
      default:   ok = (n >= 1) && (n <= maxb);
    endcase
    return ok;
  endfunction

  // Next unlock state after a status write
  function automatic unlock_t unlock_next(unlock_t cur, logic valid, logic [7:0] key,
                                          logic [7:0] k_arm, logic [7:0] k_open);
    unlock_t nx;
    nx = '0;
    if (valid) begin
      if (key == k_arm) begin
        nx.arm  = 1'b1;
        nx.open = 1'b0;
      end else if (key == k_open && cur.arm) begin
        nx.arm  = 1'b1;
        nx.open = 1'b1;
      end
    end
    return nx;
  endfunction

endpackage

// File: rtl/ccr_gate_decode.sv
module ccr_gate_decode
  import ccr_gate_pkg::*;
#(
  parameter int unsigned ADDR_W      = 6,
  parameter int unsigned STATUS_ADDR = 63,
  parameter int unsigned TIME_BASE   = 48,
  parameter int unsigned TIME_SPAN   = 8,
  parameter int unsigned ALARM_BASE  = 0,
  parameter int unsigned ALARM_SPAN  = 16
) (
  input  logic [ADDR_W-1:0] addr,
  output grp_e              grp,
  output logic              at_time_base
);

  logic [31:0] a_ext;
  assign a_ext = 32'(addr);

  always_comb begin
    if (a_ext == STATUS_ADDR)
      grp = GRP_STATUS;
    else if (in_window(a_ext, TIME_BASE, TIME_SPAN))
      grp = GRP_TIME;
    else if (in_window(a_ext, ALARM_BASE, ALARM_SPAN))
      grp = GRP_ALARM;
    else
      grp = GRP_OTHER;
  end

  assign at_time_base = (a_ext == TIME_BASE);

endmodule

// File: rtl/ccr_gate_length.sv
module ccr_gate_length
  import ccr_gate_pkg::*;
#(
  parameter int unsigned LEN_W     = 4,
  parameter int unsigned TIME_SPAN = 8,
  parameter int unsigned MAX_BYTES = 8
) (
  input  grp_e             grp,
  input  logic             at_time_base,
  input  logic [LEN_W-1:0] len,
  output logic             len_ok
);

  assign len_ok = len_legal(grp, at_time_base, 32'(len), TIME_SPAN, MAX_BYTES);

endmodule

// File: rtl/ccr_gate_unlock.sv
module ccr_gate_unlock
  import ccr_gate_pkg::*;
#(
  parameter int unsigned LEN_W     = 4,
  parameter int unsigned MAX_BYTES = 8,
  parameter logic [7:0]  KEY_ARM   = 8'h02,
  parameter logic [7:0]  KEY_OPEN  = 8'h06
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   upd,
  input  logic                   len_ok,
  input  logic [LEN_W-1:0]       len,
  input  logic [MAX_BYTES*8-1:0] data,
  output unlock_t                state
);

  logic [7:0] lane [MAX_BYTES];
  logic [7:0] last_byte;
  unlock_t    state_q;
  unlock_t    state_d;

  for (genvar g = 0; g < MAX_BYTES; g++) begin : g_lane
    assign lane[g] = data[g*8 +: 8];
  end

  // The status register keeps the last byte of the transaction
  always_comb begin
    last_byte = '0;
    for (int i = 0; i < MAX_BYTES; i++) begin
      if (32'(len) == 32'(i + 1)) last_byte = lane[i];
    end
  end

  always_comb begin
    state_d = state_q;
    if (upd) state_d = unlock_next(state_q, len_ok, last_byte, KEY_ARM, KEY_OPEN);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= '0;
    else        state_q <= state_d;
  end

  assign state = state_q;

endmodule

// File: rtl/ccr_write_gate.sv
module ccr_write_gate
  import ccr_gate_pkg::*;
#(
  parameter int unsigned ADDR_W      = 6,
  parameter int unsigned LEN_W       = 4,
  parameter int unsigned MAX_BYTES   = 8,
  parameter int unsigned STATUS_ADDR = 63,
  parameter int unsigned TIME_BASE   = 48,
  parameter int unsigned TIME_SPAN   = 8,
  parameter int unsigned ALARM_BASE  = 0,
  parameter int unsigned ALARM_SPAN  = 16,
  parameter logic [7:0]  KEY_ARM     = 8'h02,
  parameter logic [7:0]  KEY_OPEN    = 8'h06
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   txn_done,
  input  logic [ADDR_W-1:0]      txn_addr,
  input  logic [LEN_W-1:0]       txn_len,
  input  logic [MAX_BYTES*8-1:0] txn_data,
  output logic                   commit_stb,
  output logic                   we_latch,
  output logic                   rw_enable
);

  // Named internal events
  grp_e    grp;
  logic    at_time_base;
  logic    len_ok;
  logic    status_wr;
  logic    bank_wr;
  logic    unlocked;
  logic    grant;
  unlock_t ul_state;
  logic    commit_q;

  ccr_gate_decode #(
    .ADDR_W(ADDR_W), .STATUS_ADDR(STATUS_ADDR), .TIME_BASE(TIME_BASE),
    .TIME_SPAN(TIME_SPAN), .ALARM_BASE(ALARM_BASE), .ALARM_SPAN(ALARM_SPAN)
  ) u_decode (
    .addr(txn_addr), .grp(grp), .at_time_base(at_time_base)
  );

  ccr_gate_length #(
    .LEN_W(LEN_W), .TIME_SPAN(TIME_SPAN), .MAX_BYTES(MAX_BYTES)
  ) u_length (
    .grp(grp), .at_time_base(at_time_base), .len(txn_len), .len_ok(len_ok)
  );

  assign status_wr = txn_done && (grp == GRP_STATUS);
  assign bank_wr   = txn_done && (grp != GRP_STATUS);

  ccr_gate_unlock #(
    .LEN_W(LEN_W), .MAX_BYTES(MAX_BYTES), .KEY_ARM(KEY_ARM), .KEY_OPEN(KEY_OPEN)
  ) u_unlock (
    .clk(clk), .rst_n(rst_n), .upd(status_wr), .len_ok(len_ok),
    .len(txn_len), .data(txn_data), .state(ul_state)
  );

  assign unlocked = ul_state.arm && ul_state.open;
  assign grant    = bank_wr && len_ok && unlocked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) commit_q <= 1'b0;
    else        commit_q <= grant;
  end

  assign commit_stb = commit_q;
  assign we_latch   = ul_state.arm;
  assign rw_enable  = ul_state.open;

endmodule

// File: rtl/ccr_write_gate_chk.sv
module ccr_write_gate_chk #(
  parameter int unsigned ADDR_W      = 6,
  parameter int unsigned LEN_W       = 4,
  parameter int unsigned MAX_BYTES   = 8,
  parameter int unsigned STATUS_ADDR = 63,
  parameter int unsigned TIME_BASE   = 48,
  parameter int unsigned TIME_SPAN   = 8,
  parameter int unsigned ALARM_BASE  = 0,
  parameter int unsigned ALARM_SPAN  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              txn_done,
  input logic [ADDR_W-1:0] txn_addr,
  input logic [LEN_W-1:0]  txn_len,
  input logic              commit_stb,
  input logic              we_latch,
  input logic              rw_enable
);

  logic [31:0] a32;
  logic [31:0] n32;
  logic        to_status;
  logic        to_time;
  logic        to_alarm;

  assign a32       = 32'(txn_addr);
  assign n32       = 32'(txn_len);
  assign to_status = (a32 == STATUS_ADDR);
  assign to_time   = (a32 >= TIME_BASE) && (a32 < TIME_BASE + TIME_SPAN);
  assign to_alarm  = (a32 >= ALARM_BASE) && (a32 < ALARM_BASE + ALARM_SPAN) && !to_time;

  AST_OPEN_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    rw_enable |-> we_latch); // R3

  AST_COMMIT_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    commit_stb |-> $past(txn_done)); // R10

  AST_COMMIT_NEEDS_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    commit_stb |-> $past(we_latch && rw_enable)); // R5

  AST_STATUS_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_done && to_status) |=> !commit_stb); // R2

  AST_BITS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(txn_done && to_status) |=> ($stable(we_latch) && $stable(rw_enable))); // R9

  AST_TIME_PAGE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_done && to_time && !(a32 == TIME_BASE && n32 == TIME_SPAN)) |=> !commit_stb); // R6

  AST_ALARM_MULTI: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_done && to_alarm && n32 < 2) |=> !commit_stb); // R7

  AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_done && (n32 == 0 || n32 > MAX_BYTES)) |=> !commit_stb); // R11

endmodule

bind ccr_write_gate ccr_write_gate_chk #(
  .ADDR_W(ADDR_W), .LEN_W(LEN_W), .MAX_BYTES(MAX_BYTES), .STATUS_ADDR(STATUS_ADDR),
  .TIME_BASE(TIME_BASE), .TIME_SPAN(TIME_SPAN), .ALARM_BASE(ALARM_BASE),
  .ALARM_SPAN(ALARM_SPAN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .txn_done(txn_done), .txn_addr(txn_addr),
  .txn_len(txn_len), .commit_stb(commit_stb), .we_latch(we_latch),
  .rw_enable(rw_enable)
);

// File: tb/ccr_write_gate_tb.sv
module ccr_write_gate_tb;

  localparam int AW = 6;
  localparam int LW = 4;
  localparam int MB = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          txn_done;
  logic [AW-1:0] txn_addr;
  logic [LW-1:0] txn_len;
  logic [MB*8-1:0] txn_data;
  logic          commit_stb;
  logic          we_latch;
  logic          rw_enable;

  always #5 clk = ~clk;

  ccr_write_gate u_dut (
    .clk(clk), .rst_n(rst_n), .txn_done(txn_done), .txn_addr(txn_addr),
    .txn_len(txn_len), .txn_data(txn_data), .commit_stb(commit_stb),
    .we_latch(we_latch), .rw_enable(rw_enable)
  );

  typedef struct {
    logic  c;
    logic  a;
    logic  o;
    string tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;
  logic m_arm  = 1'b0;
  logic m_open = 1'b0;

  task automatic check(string tag, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  // Filler bytes everywhere, key value in the final lane of the transaction
  function automatic logic [MB*8-1:0] pack(int len, logic [7:0] v);
    logic [MB*8-1:0] d;
    for (int i = 0; i < MB; i++) d[i*8 +: 8] = 8'hA5 ^ 8'(i);
    if (len >= 1 && len <= MB) d[(len-1)*8 +: 8] = v;
    return d;
  endfunction

  // Driver: drive at a falling edge, predict, push
  task automatic send(int addr, int len, logic [MB*8-1:0] data, string tag);
    exp_t e;
    logic ok;
    logic [7:0] key;
    txn_addr = AW'(addr);
    txn_len  = LW'(len);
    txn_data = data;
    txn_done = 1'b1;
    e.c = 1'b0;
    if (addr == 63) begin
      if (len >= 1 && len <= MB) begin
        key = data[(len-1)*8 +: 8];
        if (key == 8'h02) begin
          m_arm = 1'b1; m_open = 1'b0;
        end else if (key == 8'h06 && m_arm) begin
          m_open = 1'b1;
        end else begin
          m_arm = 1'b0; m_open = 1'b0;
        end
      end else begin
        m_arm = 1'b0; m_open = 1'b0;
      end
    end else begin
      if (addr >= 48 && addr <= 55)  ok = (addr == 48) && (len == 8);
      else if (addr < 16)            ok = (len > 1) && (len <= MB);
      else                           ok = (len > 0) && (len <= MB);
      e.c = ok && m_arm && m_open;
    end
    e.a = m_arm;
    e.o = m_open;
    e.tag = tag;
    q.push_back(e);
    @(negedge clk);
    txn_done = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    m_arm = 1'b0;
    m_open = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", "commit in reset", commit_stb, 1'b0);
    check("R1", "we_latch in reset", we_latch, 1'b0);
    check("R1", "rw_enable in reset", rw_enable, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "we_latch after reset", we_latch, 1'b0);
    check("R1", "rw_enable after reset", rw_enable, 1'b0);
  endtask

  // Monitor: pops a prediction for each done strobe
  initial begin
    forever begin
      @(posedge clk);
      if (rst_n) begin
        if (txn_done) begin
          @(negedge clk);
          if (q.size() == 0) begin
            errors++;
            $display("FAIL R10 no prediction actual=%0b expected=queued", commit_stb);
          end else begin
            exp_t e;
            e = q.pop_front();
            check(e.tag, "commit_stb", commit_stb, e.c);
            check(e.tag, "we_latch", we_latch, e.a);
            check(e.tag, "rw_enable", rw_enable, e.o);
          end
        end else begin
          @(negedge clk);
          check("R10", "commit without done", commit_stb, 1'b0);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    txn_done = 1'b0;
    txn_addr = '0;
    txn_len  = '0;
    txn_data = '0;
    do_reset();

    send(20, 1, pack(1, 8'h11), "R5");          // locked: rejected
    idle(1);
    send(63, 1, pack(1, 8'h02), "R2");          // arm
    idle(1);
    send(63, 1, pack(1, 8'h06), "R3");          // open
    idle(1);
    send(20, 1, pack(1, 8'h33), "R8");          // other, one byte
    send(40, 4, pack(4, 8'h44), "R8");          // back-to-back
    send(48, 8, pack(8, 8'h55), "R6");          // full time page
    send(50, 1, pack(1, 8'h66), "R6");          // single time register
    send(49, 8, pack(8, 8'h66), "R6");          // page not at base
    send(48, 7, pack(7, 8'h66), "R6");          // short page
    send(3, 1, pack(1, 8'h77), "R7");           // alarm single byte
    send(3, 2, pack(2, 8'h77), "R7");           // alarm two bytes
    send(8, 8, pack(8, 8'h77), "R7");           // alarm page
    send(20, 0, pack(0, 8'h00), "R11");         // zero length
    send(20, 9, pack(9, 8'h00), "R11");         // over length
    idle(2);
    check("R9", "we_latch held", we_latch, 1'b1);
    check("R9", "rw_enable held", rw_enable, 1'b1);
    send(63, 2, pack(2, 8'h06), "R4");          // length 2 with key 06, arm set: opens again
    send(63, 1, pack(1, 8'h02), "R2");          // re-arm drops open
    send(63, 1, pack(1, 8'h07), "R4");          // bad key clears
    send(63, 1, pack(1, 8'h06), "R3");          // open without arm clears
    send(63, 2, {48'h0, 8'h06, 8'h02}, "R3");   // 02 then 06 in one transaction
    send(63, 1, pack(1, 8'h02), "R2");
    send(63, 0, pack(0, 8'h02), "R4");          // zero-length status clears
    send(63, 1, pack(1, 8'h02), "R2");
    send(63, 1, pack(1, 8'h06), "R3");
    send(63, 9, pack(9, 8'h02), "R4");          // over-length status clears
    send(20, 1, pack(1, 8'h12), "R5");
    send(63, 1, pack(1, 8'h02), "R2");
    send(63, 1, pack(1, 8'h06), "R3");
    send(30, 3, pack(3, 8'h21), "R9");
    idle(2);
    do_reset();
    send(20, 1, pack(1, 8'h13), "R1");          // blocked after reset
    idle(3);
    if (q.size() != 0) begin
      errors++;
      $display("FAIL R10 pending predictions actual=%0d expected=0", q.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule